// File: doc/BRIEF.md
# External Memory Bus Controller

This block sits between a CPU's internal load/store port and an external asynchronous memory bus. The CPU hands it one byte or word request at a time: a direction, a size flag, a 24-bit byte address and write data. The block runs the matching strobe sequence on the external pins and then returns a one-clock completion pulse, together with read data or status flags.

Two mode inputs set up the external bus. One picks a 16-bit or 8-bit data path. The other picks a 16 MB space, where all 24 address pins are used, or a 1 MB space, where only the low 20 pins carry address.

Addresses that fall in the on-chip ROM or RAM windows never reach the pins. The block completes them at once and raises an internal flag. Word requests at odd addresses are refused. On an 8-bit bus, a word is moved as two byte transfers on the upper lane, high-order byte first.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and right after it is released, all four strobes (`ext_as_n`, `ext_rd_n`, `ext_hwr_n`, `ext_lwr_n`) are high, `rsp_done` is low, `req_ready` is high and the data pins are released.
- R2: Each external transfer lasts exactly 3 clocks with `ext_as_n` low. The first clock is address setup. `ext_rd_n` is low only in the second clock. Read data on the pins is captured at the end of that second clock.
- R3: In 16-bit mode, a byte write at an even address pulses only `ext_hwr_n`, with the byte on bits 15:8. A byte write at an odd address pulses only `ext_lwr_n`, with the byte on bits 7:0. A word write pulses both strobes together, with bits 15:8 of the word going to the even address. A byte read returns the lane that matches the address parity in `rsp_rdata[7:0]`, with the upper byte zero.
- R4: In 8-bit mode, `ext_lwr_n` is never asserted and bits 7:0 of the data pins are never driven. All writes use `ext_hwr_n`. All data moves on bits 15:8. A byte read returns that lane in `rsp_rdata[7:0]`, with the upper byte zero.
- R5: In 8-bit mode, a word access runs two back-to-back transfers. The first uses the word address and the second uses the word address plus one. Read data is assembled with the first byte in `rsp_rdata[15:8]`. Write data sends bits 15:8 first.
- R6: An effective address inside the ROM window [0x000000, 0x008000) or the RAM window [0x0FF000, 0x100000) produces no strobe of any kind. `rsp_done` and `rsp_int` are high in the clock right after the request is accepted.
- R7: A word request with address bit 0 set produces no strobe. `rsp_done` and `rsp_err` are high in the clock right after it is accepted.
- R8: In 1 MB mode, address bits 23:20 are forced to zero before the window decode and on `ext_addr`, and `ext_addr_hi_en` is low. In 16 MB mode, all 24 bits pass through unchanged and `ext_addr_hi_en` is high.
- R9: The block drives the data pins only in the second and third clocks of a write transfer, and only on the lanes that write uses. The pins are released during reads and while the bus is idle.
- R10: Each accepted request yields exactly one `rsp_done`, and that pulse lasts one clock. `req_ready` is high only while no external transfer is in progress.
- R11: A read or write strobe is never low unless `ext_as_n` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | 1 selects the 16-bit data path, 0 the 8-bit path |
| cfg_wide | input | 1 | 1 selects the 16 MB space, 0 the 1 MB space |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | With `rsp_done`: misaligned word refused |
| rsp_int | output | 1 | With `rsp_done`: access hit an on-chip window |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` on reads |
| ext_addr | output | 24 | External address |
| ext_addr_hi_en | output | 1 | High when bits 23:20 carry address |
| ext_data | inout | 16 | External data pins |
| ext_as_n | output | 1 | Address strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_hwr_n | output | 1 | Even/upper-lane write strobe, active low |
| ext_lwr_n | output | 1 | Odd/lower-lane write strobe, active low |

## Verification
A wrong phase or beat register shows at the pins within one transfer. It appears as an address-strobe run that is not a multiple of 3 clocks, a strobe count that differs from what the size and mode predict, or a second 8-bit beat on the wrong address. A slip in lane selection or byte reassembly shows on the next read-back: the read data comes back with swapped or stale bytes compared with a shadow model of the external memory. A decode fault shows in the same clock as the completion pulse, as a missing internal flag or as strobes toggling for an on-chip address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   // Phase of one external byte/word transfer
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,   // address setup, AS low
      PH_STRB = 2'd2,   // read or write strobe low
      PH_HOLD = 2'd3    // strobes released, write data held
   } xbus_phase_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned NARROW_AW = 20,
   parameter bit          ROM_EN    = 1'b1,
   parameter int unsigned ROM_BASE  = 32'h0000_0000,
   parameter int unsigned ROM_SIZE  = 32'h0000_8000,
   parameter bit          RAM_EN    = 1'b1,
   parameter int unsigned RAM_BASE  = 32'h000F_F000,
   parameter int unsigned RAM_SIZE  = 32'h0000_1000
) (
   input  logic [ADDR_W-1:0] raw_addr,
   input  logic              wide_space,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              int_hit
);

   localparam int unsigned CW = ADDR_W + 1;
   localparam logic [CW-1:0] ROM_LO = CW'(ROM_BASE);
   localparam logic [CW-1:0] ROM_HI = CW'(ROM_BASE) + CW'(ROM_SIZE);
   localparam logic [CW-1:0] RAM_LO = CW'(RAM_BASE);
   localparam logic [CW-1:0] RAM_HI = CW'(RAM_BASE) + CW'(RAM_SIZE);

   if (NARROW_AW >= ADDR_W) begin : g_bad_narrow
      $error("xbus_decode: NARROW_AW must be below ADDR_W");
   end
   if (ROM_EN && ROM_SIZE == 0) begin : g_bad_rom
      $error("xbus_decode: enabled ROM window has zero size");
   end
   if (RAM_EN && RAM_SIZE == 0) begin : g_bad_ram
      $error("xbus_decode: enabled RAM window has zero size");
   end

   logic [CW-1:0] cmp_addr;
   logic          rom_hit;
   logic          ram_hit;

   always_comb begin
      eff_addr = raw_addr;
      if (!wide_space) begin
         eff_addr[ADDR_W-1:NARROW_AW] = '0;
      end
   end

   assign cmp_addr = {1'b0, eff_addr};

   if (ROM_EN) begin : g_rom
      assign rom_hit = (cmp_addr >= ROM_LO) && (cmp_addr < ROM_HI);
   end else begin : g_no_rom
      assign rom_hit = 1'b0;
   end

   if (RAM_EN) begin : g_ram
      assign ram_hit = (cmp_addr >= RAM_LO) && (cmp_addr < RAM_HI);
   end else begin : g_no_ram
      assign ram_hit = 1'b0;
   end

   assign int_hit = rom_hit | ram_hit;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              int_hit,
   input  logic              bus16_in,
   input  logic [DATA_W-1:0] din,
   output logic              req_ready,
   output xbus_phase_e       phase,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              wr_q,
   output logic              word_q,
   output logic              bus16_q,
   output logic              beat_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic              rsp_int,
   output logic [DATA_W-1:0] rsp_rdata
);

   localparam int unsigned HI_LSB = DATA_W - BYTE_W;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("xbus_seq: data path must be exactly two byte lanes");
   end

   logic              accept;
   logic              misaligned;
   logic              two_beat;
   logic [DATA_W-1:0] acc_q;
   logic [BYTE_W-1:0] hi_lane;
   logic [BYTE_W-1:0] lo_lane;

   assign req_ready  = (phase == PH_IDLE);
   assign accept     = req_valid && req_ready;
   assign misaligned = req_word && eff_addr[0];
   assign two_beat   = word_q && !bus16_q;
   assign hi_lane    = din[DATA_W-1:HI_LSB];
   assign lo_lane    = din[BYTE_W-1:0];

   // phase sequencing and request latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cur_addr <= '0;
         wr_q     <= 1'b0;
         word_q   <= 1'b0;
         bus16_q  <= 1'b1;
         beat_q   <= 1'b0;
         wdata_q  <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (accept && !misaligned && !int_hit) begin
                  phase    <= PH_ADDR;
                  cur_addr <= eff_addr;
                  wr_q     <= req_write;
                  word_q   <= req_word;
                  bus16_q  <= bus16_in;
                  beat_q   <= 1'b0;
                  wdata_q  <= req_wdata;
               end
            end
            PH_ADDR: phase <= PH_STRB;
            PH_STRB: phase <= PH_HOLD;
            PH_HOLD: begin
               if (two_beat && !beat_q) begin
                  phase    <= PH_ADDR;
                  beat_q   <= 1'b1;
                  cur_addr <= cur_addr + ADDR_W'(1);
               end else begin
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // read capture at the end of the strobe clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (phase == PH_STRB && !wr_q) begin
         if (bus16_q) begin
            if (word_q) begin
               acc_q <= din;
            end else begin
               acc_q <= {{BYTE_W{1'b0}}, (cur_addr[0] ? lo_lane : hi_lane)};
            end
         end else begin
            if (!word_q) begin
               acc_q <= {{BYTE_W{1'b0}}, hi_lane};
            end else if (!beat_q) begin
               acc_q[DATA_W-1:HI_LSB] <= hi_lane;
            end else begin
               acc_q[BYTE_W-1:0] <= hi_lane;
            end
         end
      end
   end

   // completion handshake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_int   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= 1'b0;
         if (accept && misaligned) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
            rsp_int  <= 1'b0;
         end else if (accept && int_hit) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b0;
            rsp_int  <= 1'b1;
         end else if (phase == PH_HOLD && !(two_beat && !beat_q)) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b0;
            rsp_int  <= 1'b0;
            if (!wr_q) begin
               rsp_rdata <= acc_q;
            end
         end
      end
   end

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
   import xbus_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned LANES = DATA_W / BYTE_W
) (
   input  xbus_phase_e       phase,
   input  logic              wr_q,
   input  logic              word_q,
   input  logic              bus16_q,
   input  logic              addr_lsb,
   input  logic              beat_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic              as_n,
   output logic              rd_n,
   output logic              hwr_n,
   output logic              lwr_n,
   output logic [LANES-1:0]  drv,
   output logic [DATA_W-1:0] dout
);

   logic strobe_ph;
   logic data_ph;
   logic sel_hi;
   logic sel_lo;
   logic [BYTE_W-1:0] byte_out;

   assign strobe_ph = (phase == PH_STRB);
   assign data_ph   = (phase == PH_STRB) || (phase == PH_HOLD);

   always_comb begin
      if (bus16_q) begin
         sel_hi = word_q || !addr_lsb;
         sel_lo = word_q ||  addr_lsb;
      end else begin
         sel_hi = 1'b1;
         sel_lo = 1'b0;
      end
   end

   // byte that travels on the upper lane in 8-bit mode
   always_comb begin
      if (word_q && !beat_q) begin
         byte_out = wdata_q[DATA_W-1:DATA_W-BYTE_W];
      end else begin
         byte_out = wdata_q[BYTE_W-1:0];
      end
   end

   always_comb begin
      if (bus16_q && word_q) begin
         dout = wdata_q;
      end else if (bus16_q) begin
         dout = {wdata_q[BYTE_W-1:0], wdata_q[BYTE_W-1:0]};
      end else begin
         dout = {byte_out, {BYTE_W{1'b0}}};
      end
   end

   assign as_n  = (phase == PH_IDLE);
   assign rd_n  = !(strobe_ph && !wr_q);
   assign hwr_n = !(strobe_ph && wr_q && sel_hi);
   assign lwr_n = !(strobe_ph && wr_q && sel_lo);

   always_comb begin
      drv = '0;
      drv[LANES-1] = wr_q && data_ph && sel_hi;
      drv[0]       = wr_q && data_ph && sel_lo;
   end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned NARROW_AW = 20,
   parameter int unsigned DATA_W    = 16,
   parameter bit          ROM_EN    = 1'b1,
   parameter int unsigned ROM_BASE  = 32'h0000_0000,
   parameter int unsigned ROM_SIZE  = 32'h0000_8000,
   parameter bit          RAM_EN    = 1'b1,
   parameter int unsigned RAM_BASE  = 32'h000F_F000,
   parameter int unsigned RAM_SIZE  = 32'h0000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus16,
   input  logic              cfg_wide,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic              rsp_int,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ext_addr,
   output logic              ext_addr_hi_en,
   inout  wire  [DATA_W-1:0] ext_data,
   output logic              ext_as_n,
   output logic              ext_rd_n,
   output logic              ext_hwr_n,
   output logic              ext_lwr_n
);

   localparam int unsigned LANES = DATA_W / BYTE_W;

   if (DATA_W % BYTE_W != 0) begin : g_bad_lanes
      $error("xbus_ctrl: data width must be a whole number of bytes");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              int_hit;
   xbus_phase_e       phase;
   logic [ADDR_W-1:0] cur_addr;
   logic              wr_q;
   logic              word_q;
   logic              bus16_q;
   logic              beat_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  lane_drv;
   logic [DATA_W-1:0] lane_dout;
   logic [DATA_W-1:0] din;

   xbus_decode #(
      .ADDR_W(ADDR_W), .NARROW_AW(NARROW_AW),
      .ROM_EN(ROM_EN), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
      .RAM_EN(RAM_EN), .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
   ) u_decode (
      .raw_addr   (req_addr),
      .wide_space (cfg_wide),
      .eff_addr   (eff_addr),
      .int_hit    (int_hit)
   );

   xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_word  (req_word),
      .req_wdata (req_wdata),
      .eff_addr  (eff_addr),
      .int_hit   (int_hit),
      .bus16_in  (cfg_bus16),
      .din       (din),
      .req_ready (req_ready),
      .phase     (phase),
      .cur_addr  (cur_addr),
      .wr_q      (wr_q),
      .word_q    (word_q),
      .bus16_q   (bus16_q),
      .beat_q    (beat_q),
      .wdata_q   (wdata_q),
      .rsp_done  (rsp_done),
      .rsp_err   (rsp_err),
      .rsp_int   (rsp_int),
      .rsp_rdata (rsp_rdata)
   );

   xbus_lane #(.DATA_W(DATA_W)) u_lane (
      .phase    (phase),
      .wr_q     (wr_q),
      .word_q   (word_q),
      .bus16_q  (bus16_q),
      .addr_lsb (cur_addr[0]),
      .beat_q   (beat_q),
      .wdata_q  (wdata_q),
      .as_n     (ext_as_n),
      .rd_n     (ext_rd_n),
      .hwr_n    (ext_hwr_n),
      .lwr_n    (ext_lwr_n),
      .drv      (lane_drv),
      .dout     (lane_dout)
   );

   assign din            = ext_data;
   assign ext_addr       = cur_addr;
   assign ext_addr_hi_en = cfg_wide;

   for (genvar g = 0; g < LANES; g++) begin : g_pad
      assign ext_data[g*BYTE_W +: BYTE_W] =
         lane_drv[g] ? lane_dout[g*BYTE_W +: BYTE_W] : {BYTE_W{1'bz}};
   end

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned NARROW_AW = 20,
   parameter int unsigned LANES     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_bus16,
   input logic              cfg_wide,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_word,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic              rsp_int,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ext_addr_hi_en,
   input logic              ext_as_n,
   input logic              ext_rd_n,
   input logic              ext_hwr_n,
   input logic              ext_lwr_n,
   input logic [LANES-1:0]  lane_drv
);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_idle_chk: assert (ext_as_n && ext_rd_n && ext_hwr_n && ext_lwr_n
                                 && !rsp_done && req_ready && lane_drv == '0);
      end
   end

   // R11
   rd_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n |-> !ext_as_n);

   // R11
   wr_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_hwr_n || !ext_lwr_n) |-> !ext_as_n);

   // R2
   rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_rd_n) |-> $past(!ext_as_n));

   // R2
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n |=> ext_rd_n);

   // R4
   narrow_lwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_bus16 |-> ext_lwr_n);

   // R4
   narrow_lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_bus16 |-> !lane_drv[0]);

   // R9
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_as_n || !ext_rd_n) |-> (lane_drv == '0));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7
   odd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_word && req_addr[0])
         |=> (rsp_done && rsp_err && ext_as_n));

   // R6
   int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_int) |-> (ext_as_n && !rsp_err));

   // R8
   narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wide && !ext_as_n) |-> (ext_addr[ADDR_W-1:NARROW_AW] == '0 && !ext_addr_hi_en));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(
   .ADDR_W(ADDR_W), .NARROW_AW(NARROW_AW), .LANES(LANES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_bus16      (cfg_bus16),
   .cfg_wide       (cfg_wide),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_word       (req_word),
   .req_addr       (req_addr),
   .rsp_done       (rsp_done),
   .rsp_err        (rsp_err),
   .rsp_int        (rsp_int),
   .ext_addr       (ext_addr),
   .ext_addr_hi_en (ext_addr_hi_en),
   .ext_as_n       (ext_as_n),
   .ext_rd_n       (ext_rd_n),
   .ext_hwr_n      (ext_hwr_n),
   .ext_lwr_n      (ext_lwr_n),
   .lane_drv       (lane_drv)
);

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bus16 = 1'b1;
   logic        cfg_wide = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done, rsp_err, rsp_int;
   logic [15:0] rsp_rdata;
   logic [23:0] ext_addr;
   logic        ext_addr_hi_en;
   wire  [15:0] ext_data;
   logic        ext_as_n, ext_rd_n, ext_hwr_n, ext_lwr_n;

   always #4 clk = ~clk;

   xbus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_wide(cfg_wide),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_int(rsp_int),
      .rsp_rdata(rsp_rdata), .ext_addr(ext_addr), .ext_addr_hi_en(ext_addr_hi_en),
      .ext_data(ext_data), .ext_as_n(ext_as_n), .ext_rd_n(ext_rd_n),
      .ext_hwr_n(ext_hwr_n), .ext_lwr_n(ext_lwr_n)
   );

   int vectors = 0;
   int misses  = 0;
   int n_req   = 0;
   int n_done  = 0;
   int naked_strobe = 0;

   // external memory model (on the pins) and shadow of what it should hold
   logic [7:0] bus_mem [256];
   logic [7:0] exp_mem [256];
   logic [15:0] rd_val;
   logic [7:0]  ai;

   assign ai = ext_addr[7:0];
   always_comb begin
      if (cfg_bus16) rd_val = {bus_mem[{ai[7:1], 1'b0}], bus_mem[{ai[7:1], 1'b1}]};
      else           rd_val = {bus_mem[ai], 8'h5A};
   end
   assign ext_data = !ext_rd_n ? rd_val : 16'hzzzz;

   always @(posedge clk) begin
      if (!ext_hwr_n) begin
         if (cfg_bus16) bus_mem[{ai[7:1], 1'b0}] <= ext_data[15:8];
         else           bus_mem[ai] <= ext_data[15:8];
      end
      if (!ext_lwr_n) bus_mem[{ai[7:1], 1'b1}] <= ext_data[7:0];
   end

   typedef struct {
      bit          is_rd;
      logic [15:0] rdata;
      bit          err;
      bit          intl;
      int          as_c, rd_c, hwr_c, lwr_c;
      logic [23:0] a_first, a_last;
      string       tag;
   } exp_t;

   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // monitor: count pin activity per request, compare at completion
   int as_c = 0, rd_c = 0, hwr_c = 0, lwr_c = 0, beats = 0;
   logic [23:0] a_first = '0, a_last = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!ext_as_n) as_c++;
         if (!ext_rd_n) rd_c++;
         if (!ext_hwr_n) hwr_c++;
         if (!ext_lwr_n) lwr_c++;
         if ((!ext_rd_n || !ext_hwr_n || !ext_lwr_n) && ext_as_n) naked_strobe++;
         if (!ext_rd_n || !ext_hwr_n || !ext_lwr_n) begin
            if (beats == 0) a_first = ext_addr;
            a_last = ext_addr;
            beats++;
         end
         if (rsp_done) begin
            n_done++;
            if (sb.size() == 0) begin
               check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(rsp_err == e.err, e.tag, "err", rsp_err, e.err);
               check(rsp_int == e.intl, e.tag, "int", rsp_int, e.intl);
               check(as_c == e.as_c, e.tag, "as cycles", as_c, e.as_c);
               check(rd_c == e.rd_c, e.tag, "rd cycles", rd_c, e.rd_c);
               check(hwr_c == e.hwr_c, e.tag, "hwr cycles", hwr_c, e.hwr_c);
               check(lwr_c == e.lwr_c, e.tag, "lwr cycles", lwr_c, e.lwr_c);
               if (e.as_c != 0) begin
                  check(a_first == e.a_first, e.tag, "first addr", a_first, e.a_first);
                  check(a_last == e.a_last, e.tag, "last addr", a_last, e.a_last);
               end
               if (e.is_rd && !e.err && !e.intl)
                  check(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
            end
            as_c = 0; rd_c = 0; hwr_c = 0; lwr_c = 0; beats = 0;
         end
      end
   end

   // driver: compute expectation from the requirements, push, apply
   task automatic do_req(input bit wr, input bit word, input logic [23:0] a,
                         input logic [15:0] wd, input string tag);
      exp_t e;
      logic [23:0] ea;
      logic [7:0]  i;
      bit odd, intl;
      int nb;
      ea   = cfg_wide ? a : {4'h0, a[19:0]};
      odd  = word && a[0];
      intl = !odd && ((ea < 24'h008000) || (ea >= 24'h0FF000 && ea < 24'h100000));
      nb   = (odd || intl) ? 0 : ((word && !cfg_bus16) ? 2 : 1);
      i    = ea[7:0];
      e.is_rd = !wr;
      e.err   = odd;
      e.intl  = intl;
      e.as_c  = 3 * nb;
      e.rd_c  = wr ? 0 : nb;
      e.hwr_c = 0;
      e.lwr_c = 0;
      if (wr && nb > 0) begin
         if (cfg_bus16) begin
            e.hwr_c = (word || !a[0]) ? 1 : 0;
            e.lwr_c = (word ||  a[0]) ? 1 : 0;
         end else begin
            e.hwr_c = nb;
         end
      end
      e.a_first = ea;
      e.a_last  = (nb == 2) ? ea + 24'd1 : ea;
      e.rdata   = word ? {exp_mem[i], exp_mem[i + 8'd1]} : {8'h00, exp_mem[i]};
      e.tag     = tag;
      if (wr && nb > 0) begin
         if (word) begin
            exp_mem[i] = wd[15:8];
            exp_mem[i + 8'd1] = wd[7:0];
         end else begin
            exp_mem[i] = wd[7:0];
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = word;
      req_addr = a; req_wdata = wd;
      sb.push_back(e);
      n_req++;
      @(negedge clk);
      req_valid = 1'b0;
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      misses++;
      $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
   end

   initial begin
      for (int k = 0; k < 256; k++) begin
         bus_mem[k] = 8'(k * 37 + 11);
         exp_mem[k] = 8'(k * 37 + 11);
      end
      repeat (3) @(negedge clk);
      // R1 while reset held
      check(ext_as_n && ext_rd_n && ext_hwr_n && ext_lwr_n, "R1", "strobes in reset", 0, 1);
      check(!rsp_done && req_ready, "R1", "handshake in reset", 0, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(ext_as_n && ext_rd_n && ext_hwr_n && ext_lwr_n && !rsp_done,
            "R1", "idle after reset", 0, 1);

      // 16-bit data path, 16 MB space
      cfg_bus16 = 1'b1; cfg_wide = 1'b1;
      @(negedge clk);
      check(ext_addr_hi_en == 1'b1, "R8", "hi_en wide", ext_addr_hi_en, 1);
      do_req(0, 1, 24'h100010, 16'h0000, "R2");
      do_req(0, 0, 24'h100020, 16'h0000, "R3");
      do_req(0, 0, 24'h100021, 16'h0000, "R3");
      do_req(1, 1, 24'h100030, 16'hA55A, "R3");
      do_req(0, 1, 24'h100030, 16'h0000, "R9");
      do_req(1, 0, 24'h100041, 16'h003C, "R3");
      do_req(1, 0, 24'h100042, 16'h00C3, "R3");
      do_req(0, 1, 24'h100040, 16'h0000, "R3");
      do_req(0, 1, 24'h100042, 16'h0000, "R9");
      do_req(0, 1, 24'h100051, 16'h0000, "R7");
      do_req(1, 1, 24'h100053, 16'hFFFF, "R7");
      do_req(0, 1, 24'h000100, 16'h0000, "R6");
      do_req(1, 1, 24'h0FF010, 16'h1234, "R6");
      do_req(0, 1, 24'h1FF010, 16'h0000, "R8");
      do_req(0, 0, 24'h007FFF, 16'h0000, "R6");
      do_req(0, 0, 24'h008000, 16'h0000, "R6");

      // 1 MB space
      cfg_wide = 1'b0;
      @(negedge clk);
      check(ext_addr_hi_en == 1'b0, "R8", "hi_en narrow", ext_addr_hi_en, 0);
      do_req(0, 1, 24'h1FF012, 16'h0000, "R8");
      do_req(0, 1, 24'h3A0060, 16'h0000, "R8");

      // 8-bit data path, 16 MB space
      cfg_bus16 = 1'b0; cfg_wide = 1'b1;
      do_req(0, 1, 24'h100070, 16'h0000, "R5");
      do_req(1, 1, 24'h100080, 16'hBEEF, "R5");
      do_req(0, 0, 24'h100080, 16'h0000, "R4");
      do_req(0, 0, 24'h100081, 16'h0000, "R4");
      do_req(0, 1, 24'h100080, 16'h0000, "R5");
      do_req(1, 0, 24'h100091, 16'h0077, "R4");
      do_req(0, 0, 24'h100091, 16'h0000, "R4");
      do_req(0, 1, 24'h100095, 16'h0000, "R7");
      do_req(0, 1, 24'h000200, 16'h0000, "R6");

      // back to 16-bit, confirm lanes written in 8-bit mode
      cfg_bus16 = 1'b1;
      do_req(0, 1, 24'h100090, 16'h0000, "R3");

      repeat (4) @(negedge clk);
      check(n_done == n_req, "R10", "done count", n_done, n_req);
      check(naked_strobe == 0, "R11", "strobe without AS", naked_strobe, 0);
      for (int k = 0; k < 256; k++) begin
         if (bus_mem[k] != exp_mem[k])
            check(1'b0, "R3", $sformatf("mem[%0h]", k), bus_mem[k], exp_mem[k]);
      end
      check(1'b1, "R4", "memory image compared", 1, 1);
      finish_run();
   end

endmodule